// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Checker

This block sits beside a DDR SDRAM command bus and samples it on every rising clock edge. From the clock-enable level (current and the one registered on the previous edge), chip select, the three strobes, the bank-address bits and the A10 line it names one command per cycle. It keeps a live view of which banks hold an open row, and it flags protocol violations against that view.

The rules it enforces are the all-banks-idle precondition for mode-register programming and for both kinds of refresh, a fixed quiet gap after a mode-register write, and bank-level consistency: column commands need an open bank and an activate needs an idle one. A10 selects single-bank versus all-bank precharge and plain versus auto-precharge column access. A command that violates a rule is reported and not applied to the bank view. Everything observable is registered, so the decoded command, the bank view and the error state all change on the edge that samples the bus.

Top module: `sdram_cmd_watch`

## Requirements
- R1: With clock enable high on both the previous and the current sample and chip select low, the levels {ras_n,cas_n,we_n} decode onto cmd_o as: 000 mode-register write (1), 001 auto refresh (2), 011 activate (4), 101 read (5 or 6), 100 write (7 or 8), 110 burst stop (9), 010 precharge (10 or 11); cmd_o shows the result after the sampling edge.
- R2: Chip select high yields cmd_o = 0 (no operation) whatever the strobes are.
- R3: Clock enable high on the previous sample and low now, with chip select low and the auto-refresh strobe pattern, yields self-refresh entry (3); whenever the previous clock-enable sample is low, cmd_o is 0. The previous sample counts as high right after reset.
- R4: Any other combination, including strobes 111 and clock enable falling with a non-refresh pattern, yields cmd_o = 0 and changes no bank.
- R5: The bank-address value selects the bank, bank_open_o bit index equal to ba, for activate, read, write and single-bank precharge; an accepted activate sets exactly that bit.
- R6: Precharge with a10 = 1 (code 11) closes every bank and ignores ba; with a10 = 0 (code 10) it closes only bank ba.
- R7: Read or write with a10 = 1 reports the auto-precharge code (6 or 8); with a10 = 0 it reports the plain code (5 or 7).
- R8: After an accepted auto-precharge read or write on edge t, the bank stays open after edge t+1 and is idle after edge t+BURST_LEN/2 (t+2 by default).
- R9: A mode-register write while any bank is open raises error code 1.
- R10: Auto refresh or self-refresh entry while any bank is open raises error code 2.
- R11: Any command other than no-operation on the edge right after an accepted mode-register write raises error code 3; a command two edges after it is legal.
- R12: Read or write to an idle bank raises error code 4; activate to an open bank raises error code 5.
- R13: err_o is sticky until reset, err_code_o holds the code of the most recent violation, and a violating command leaves bank_open_o unchanged.
- R14: Reset leaves all banks idle, cmd_o = 0, err_o = 0 and err_code_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, current sample |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | All-bank / auto-precharge select |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | NUM_BANKS | One bit per bank, 1 = row open |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Code of the most recent violation |

## Verification
On every cycle the assertions hold the error flag sticky with a nonzero code behind it, force a deselected cycle to decode as no-operation, allow a bank to open only under a decoded activate and one bank at a time, and tie a mode-register write over an open bank to a raised error. The exact decode of each strobe pattern, the A10 split, the auto-precharge close two edges later, the post-write gap and the choice of error code only show up in the bench scenarios, which compare every output after every edge against an independent model under directed sequences and a long seeded random run.

// File: rtl/sdram_watch_pkg.sv
package sdram_watch_pkg;

    localparam int CMD_W = 4;
    localparam int ERR_W = 3;

    typedef enum logic [CMD_W-1:0] {
        C_NOP  = 4'd0,
        C_MODE = 4'd1,
        C_AREF = 4'd2,
        C_SREF = 4'd3,
        C_ACT  = 4'd4,
        C_RD   = 4'd5,
        C_RDA  = 4'd6,
        C_WR   = 4'd7,
        C_WRA  = 4'd8,
        C_BST  = 4'd9,
        C_PRE  = 4'd10,
        C_PREA = 4'd11
    } cmd_e;

    typedef enum logic [ERR_W-1:0] {
        E_NONE      = 3'd0,
        E_MODE_OPEN = 3'd1,
        E_REF_OPEN  = 3'd2,
        E_MODE_GAP  = 3'd3,
        E_RW_IDLE   = 3'd4,
        E_ACT_OPEN  = 3'd5
    } err_e;

    typedef struct packed {
        logic cke_prev;
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } pins_t;

    function automatic cmd_e decode_pins(pins_t p);
        cmd_e c;
        c = C_NOP;
        if (p.cke_prev && !p.cs_n) begin
            if (!p.cke) begin
                if (!p.ras_n && !p.cas_n && p.we_n) c = C_SREF;
            end else begin
                case ({p.ras_n, p.cas_n, p.we_n})
                    3'b000:  c = C_MODE;
                    3'b001:  c = C_AREF;
                    3'b011:  c = C_ACT;
                    3'b101:  c = p.a10 ? C_RDA : C_RD;
                    3'b100:  c = p.a10 ? C_WRA : C_WR;
                    3'b110:  c = C_BST;
                    3'b010:  c = p.a10 ? C_PREA : C_PRE;
                    default: c = C_NOP;
                endcase
            end
        end
        return c;
    endfunction

    function automatic logic is_column(cmd_e c);
        return (c == C_RD) || (c == C_RDA) || (c == C_WR) || (c == C_WRA);
    endfunction

    function automatic logic is_auto_pre(cmd_e c);
        return (c == C_RDA) || (c == C_WRA);
    endfunction

    function automatic logic needs_idle(cmd_e c);
        return (c == C_MODE) || (c == C_AREF) || (c == C_SREF);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_watch_pkg::*;
(
    input  pins_t pins_i,
    output cmd_e  cmd_o
);
    always_comb cmd_o = decode_pins(pins_i);
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
    parameter int BURST_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic close_i,
    input  logic ap_start_i,
    output logic open_o
);
    localparam int CW = $clog2(BURST_CLKS + 1);

    logic [CW-1:0] ap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            ap_cnt <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
            ap_cnt <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            ap_cnt <= '0;
        end else if (ap_start_i) begin
            ap_cnt <= CW'(BURST_CLKS);
        end else if (ap_cnt == CW'(1)) begin
            open_o <= 1'b0;
            ap_cnt <= '0;
        end else if (ap_cnt != '0) begin
            ap_cnt <= ap_cnt - CW'(1);
        end
    end
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
    import sdram_watch_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int MRD_CLKS  = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_e                 cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic [NUM_BANKS-1:0] open_i,
    output logic                 accept_o,
    output logic                 viol_o,
    output err_e                 code_o
);
    localparam int GW = $clog2(MRD_CLKS + 1);

    logic [GW-1:0] gap_cnt;
    logic          any_open;
    logic          hit_open;

    always_comb begin
        any_open = |open_i;
        hit_open = open_i[ba_i];
        code_o   = E_NONE;
        if (cmd_i != C_NOP) begin
            if (gap_cnt != '0)                          code_o = E_MODE_GAP;
            else if (cmd_i == C_MODE && any_open)       code_o = E_MODE_OPEN;
            else if (needs_idle(cmd_i) && any_open)     code_o = E_REF_OPEN;
            else if (cmd_i == C_ACT && hit_open)        code_o = E_ACT_OPEN;
            else if (is_column(cmd_i) && !hit_open)     code_o = E_RW_IDLE;
        end
        viol_o   = (code_o != E_NONE);
        accept_o = (cmd_i != C_NOP) && !viol_o;
    end

    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt <= '0;
        else if (accept_o && cmd_i == C_MODE)
            gap_cnt <= GW'(MRD_CLKS - 1);
        else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - GW'(1);
    end
endmodule

// File: rtl/sdram_cmd_watch.sv
module sdram_cmd_watch
    import sdram_watch_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int MRD_CLKS  = 2,
    localparam int BA_W       = $clog2(NUM_BANKS),
    localparam int BURST_CLKS = BURST_LEN / 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic [CMD_W-1:0]     cmd_o,
    output logic [NUM_BANKS-1:0] bank_open_o,
    output logic                 err_o,
    output logic [ERR_W-1:0]     err_code_o
);
    logic  cke_d;
    pins_t pins;
    cmd_e  cmd_now;
    cmd_e  cmd_q;
    err_e  code_now;
    err_e  code_q;
    logic  accept;
    logic  viol;
    logic  err_q;

    always_ff @(posedge clk) begin
        if (rst) cke_d <= 1'b1;
        else     cke_d <= cke;
    end

    always_comb begin
        pins.cke_prev = cke_d;
        pins.cke      = cke;
        pins.cs_n     = cs_n;
        pins.ras_n    = ras_n;
        pins.cas_n    = cas_n;
        pins.we_n     = we_n;
        pins.a10      = a10;
    end

    sdram_cmd_decode u_dec (
        .pins_i (pins),
        .cmd_o  (cmd_now)
    );

    sdram_rule_check #(
        .NUM_BANKS (NUM_BANKS),
        .MRD_CLKS  (MRD_CLKS)
    ) u_rules (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd_now),
        .ba_i     (ba),
        .open_i   (bank_open_o),
        .accept_o (accept),
        .viol_o   (viol),
        .code_o   (code_now)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(b));
        sdram_bank_slot #(
            .BURST_CLKS (BURST_CLKS)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .act_i      (accept && cmd_now == C_ACT && sel),
            .close_i    (accept && (cmd_now == C_PREA || (cmd_now == C_PRE && sel))),
            .ap_start_i (accept && is_auto_pre(cmd_now) && sel),
            .open_o     (bank_open_o[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= C_NOP;
            err_q  <= 1'b0;
            code_q <= E_NONE;
        end else begin
            cmd_q <= cmd_now;
            if (viol) begin
                err_q  <= 1'b1;
                code_q <= code_now;
            end
        end
    end

    assign cmd_o      = cmd_q;
    assign err_o      = err_q;
    assign err_code_o = code_q;
endmodule

// File: rtl/sdram_cmd_watch_chk.sv
module sdram_cmd_watch_chk
    import sdram_watch_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic [CMD_W-1:0]     cmd_o,
    input logic [NUM_BANKS-1:0] bank_open_o,
    input logic                 err_o,
    input logic [ERR_W-1:0]     err_code_o
);
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r12_code_behind_flag: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (err_code_o != 3'd0));

    a_r2_deselect_is_nop: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (cmd_o == 4'(C_NOP)));

    a_r5_open_only_by_act: assert property (@(posedge clk) disable iff (rst)
        ((bank_open_o & ~$past(bank_open_o)) != '0) |->
            ((cmd_o == 4'(C_ACT)) && ($countones(bank_open_o & ~$past(bank_open_o)) == 1)));

    a_r9_mode_over_open_flags: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == 4'(C_MODE)) && ($past(bank_open_o) != '0)) |-> err_o);
endmodule

bind sdram_cmd_watch sdram_cmd_watch_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .cmd_o       (cmd_o),
    .bank_open_o (bank_open_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/test_sdram_cmd_watch.sv
module test_sdram_cmd_watch;
    localparam int CLK_P = 10;
    localparam int NB    = 4;
    localparam int BCLK  = 2;
    localparam int MRD   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [3:0] bank_open_o;
    logic       err_o;
    logic [2:0] err_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] mopen;
    int  mcnt [NB];
    int  mgap, mcmd, mcode;
    bit  merr, mcke_prev;

    always #(CLK_P/2) clk = ~clk;

    sdram_cmd_watch i_sdram_cmd_watch (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_cmd(bit kp, bit k, bit cs, bit r, bit c, bit w, bit a);
        if (!kp || cs) return 0;
        if (!k) return (!r && !c && w) ? 3 : 0;
        if (!r && !c) return w ? 2 : 1;
        if (!r && c)  return w ? 4 : (a ? 11 : 10);
        if (r && !c)  return w ? (a ? 6 : 5) : (a ? 8 : 7);
        if (r && c && !w) return 9;
        return 0;
    endfunction

    task automatic model(input bit k, cs, r, c, w, input int b, input bit a);
        int  ec, code;
        bit  ok, cl, ac, ap;
        ec = ref_cmd(mcke_prev, k, cs, r, c, w, a);
        mcke_prev = k;
        code = 0;
        if (ec != 0) begin
            if (mgap != 0)                               code = 3;
            else if (ec == 1 && mopen != 0)              code = 1;
            else if ((ec == 2 || ec == 3) && mopen != 0) code = 2;
            else if (ec == 4 && mopen[b])                code = 5;
            else if (ec >= 5 && ec <= 8 && !mopen[b])    code = 4;
        end
        ok = (ec != 0) && (code == 0);
        for (int i = 0; i < NB; i++) begin
            cl = ok && (ec == 11 || (ec == 10 && b == i));
            ac = ok && ec == 4 && b == i;
            ap = ok && (ec == 6 || ec == 8) && b == i;
            if (cl) begin mopen[i] = 0; mcnt[i] = 0; end
            else if (ac) begin mopen[i] = 1; mcnt[i] = 0; end
            else if (ap) mcnt[i] = BCLK;
            else if (mcnt[i] == 1) begin mopen[i] = 0; mcnt[i] = 0; end
            else if (mcnt[i] != 0) mcnt[i]--;
        end
        if (ok && ec == 1) mgap = MRD - 1;
        else if (mgap > 0) mgap--;
        if (code != 0) begin merr = 1; mcode = code; end
        mcmd = ec;
    endtask

    task automatic compare(input string req);
        chk(req, "cmd", int'(cmd_o), mcmd);
        chk(req, "banks", int'(bank_open_o), int'(mopen));
        chk(req, "err", int'({err_o, err_code_o}), int'({merr, 3'(mcode)}));
    endtask

    task automatic step(input bit k, cs, r, c, w, input int b, input bit a, input string req);
        @(negedge clk);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = 2'(b); a10 = a;
        model(k, cs, r, c, w, b, a);
        @(posedge clk);
        #1;
        compare(req);
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1; cke = 1; cs_n = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        mopen = 0; mgap = 0; mcmd = 0; mcode = 0; merr = 0; mcke_prev = 1;
        for (int i = 0; i < NB; i++) mcnt[i] = 0;
        compare(req);
    endtask

    task automatic nop(input string req);        step(1,0,1,1,1,0,0,req); endtask
    task automatic mode(input string req);       step(1,0,0,0,0,0,0,req); endtask
    task automatic aref(input string req);       step(1,0,0,0,1,0,0,req); endtask
    task automatic act(input int b, input string req);           step(1,0,0,1,1,b,0,req); endtask
    task automatic rd(input int b, input bit a, input string req); step(1,0,1,0,1,b,a,req); endtask
    task automatic wr(input int b, input bit a, input string req); step(1,0,1,0,0,b,a,req); endtask
    task automatic pre(input int b, input bit a, input string req); step(1,0,0,1,0,b,a,req); endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        do_reset("R14 reset state");
        step(1,1,0,0,0,2,1,"R2 deselect");
        mode("R1 mode write idle");
        nop("R11 gap cycle nop");
        act(0, "R11 act two after mode");
        act(1, "R5 bank 1");
        act(3, "R5 bank 3");
        rd(0, 0, "R7 plain read");
        wr(1, 0, "R7 plain write");
        step(1,0,1,1,0,0,0,"R1 burst stop");
        rd(3, 1, "R7 read auto-pre");
        nop("R8 still open");
        nop("R8 closed");
        pre(1, 0, "R6 single precharge");
        act(2, "R5 bank 2");
        pre(1, 1, "R6 precharge all ignores ba");
        act(2, "R5 reopen");
        wr(2, 1, "R7 write auto-pre");
        nop("R8 write still open");
        nop("R8 write closed");
        step(0,0,0,1,1,1,0,"R4 cke fall non-refresh");
        step(0,0,0,1,1,1,0,"R3 cke low prev");
        step(1,0,0,1,1,1,0,"R3 cke rise still prev low");
        nop("R4 strobes 111");
        step(0,0,0,0,1,0,0,"R3 self-refresh entry");
        step(1,1,1,1,1,0,0,"R3 exit");
        nop("R3 settle");
        aref("R1 auto refresh idle");
        wr(2, 1, "R12 write to idle");
        nop("R13 sticky");
        act(0, "R12 open bank 0");
        act(0, "R12 act to open");
        aref("R10 refresh while open");
        step(0,0,0,0,1,0,0,"R10 self-refresh while open");
        step(1,1,1,1,1,0,0,"R10 wake");
        mode("R9 mode while open");
        pre(0, 1, "R6 close all");
        mode("R11 mode accepted");
        act(1, "R11 act too soon");
        nop("R13 bank untouched");
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 16) != 0, ($urandom % 6) == 0, 1'($urandom), 1'($urandom),
                 1'($urandom), int'($urandom % 4), 1'($urandom), "R13 random");
        end
        do_reset("R14 reset clears error");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule